// File: doc/BRIEF.md
# Debug Memory Access Port Engine

This block lets a debug host reach system memory through a small window of 32-bit registers. The host reads and writes the window over a valid/ready request interface that carries an 8-bit register offset. Accesses to the data register or to one of four banked data registers become transfers on an AHB-style master port. Accesses to every other register are served locally. The block keeps a control word, a transfer address and a data register. It applies security and debug enable gating, advances the address after each transfer, packs sub-word transfers into a single host word, and records failures in a sticky error flag.

Only one bus transfer is outstanding at any time, and the bus is never driven with bursts. The host must hold `req_valid_i`, `req_write_i`, `req_offset_i` and `req_wdata_i` stable until it sees `req_ready_o` high at a clock edge. That edge completes the access, and `rsp_rdata_o` is valid during the same cycle. For a local register, `req_ready_o` rises in the same cycle as `req_valid_i`. For a bus-backed register it stays low until the bus transfer, or every beat of a packed sequence, has finished, and it then rises for one cycle.

On the bus, each beat is one NONSEQ address phase followed by a data phase. Nothing else is issued during the data phase. `hresp_i` is sampled in the cycle where `hready_i` ends that data phase.

Top module: `dmap_engine`

## Requirements
- R1: After reset, the control word reads 0x4300_0002 with the status bits OR-ed in, and the transfer address reads 0.
- R2: The register offsets are 0x00 control, 0x04 address, 0x0C data, 0x10/0x14/0x18/0x1C banked, 0xF8 base, 0xFC identity. In the control word, bits [30], [28:24], [11:8], [5:4] and [2:0] are writable, and bit 31 is the error flag. Writes to any other offset are ignored, and reads of any other offset return 0.
- R3: Offset 0xFC returns `IDR_VALUE` with bit 16 set. Offset 0xF8 returns `rom_base_i` with bit 1 set.
- R4: A data-register access issues exactly one NONSEQ (htrans 2'b10) beat at the transfer address, with hsize equal to control bits [2:0]. A write drives the host data on hwdata. A read returns the bus read data.
- R5: `req_ready_o` stays low for W+3 cycles on a single-beat access, where W is the number of slave wait states. An address phase is always followed by an idle cycle.
- R6: With increment mode 01 (single) or 10 (packed), the address advances by 1, 2 or 4 bytes for size 000, 001 or 010. Only the low 10 bits change, and they wrap within the 1KB window. With mode 00 the address is left unchanged.
- R7: An error response leaves the address unchanged and sets control bit 31. The bit stays set through later accesses until the host writes 1 to it.
- R8: A banked access n targets address {TAR[31:4], n, 2'b00} with hsize 010. The size field and the increment field are ignored, and the address register does not change.
- R9: In packed mode, size 000 makes 4 beats and size 001 makes 2 beats. Element k of the data word maps to beat k. A read takes element k from the byte lane selected by the address. A write drives element k on every lane. With size 010, packed mode behaves as single.
- R10: Increment mode 11, or a size code from 011 to 111, on a data-register access starts no transfer and sets the error flag.
- R11: hprot[4:0] equals control bits [28:24]. hprot[6] is 0 only when bit 30 is 0 and `sec_en_i` is 1. When bit 30 is 0 and `sec_en_i` is 0, no transfer starts and the error flag is set.
- R12: When `dbg_en_i` is low, no transfer starts and the error flag is set. Control bit 23 reads `sec_en_i`, and control bit 6 reads `dbg_en_i`.
- R13: An error on a packed beat ends the sequence. No further beats are issued, and the address is left pointing at the failing element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted and completed |
| req_write_i | input | 1 | 1 for a register write |
| req_offset_i | input | 8 | Register offset |
| req_wdata_i | input | 32 | Host write data |
| rsp_rdata_o | output | 32 | Read data, valid while req_ready_o is high |
| dbg_en_i | input | 1 | Debug enable; low blocks bus transfers |
| sec_en_i | input | 1 | Secure transfer enable |
| rom_base_i | input | 32 | Tie-off value for the base-address register |
| haddr_o | output | 32 | Bus address |
| htrans_o | output | 2 | Bus transfer type (00 idle, 10 NONSEQ) |
| hwrite_o | output | 1 | Bus write |
| hsize_o | output | 3 | Bus transfer size |
| hprot_o | output | 7 | Bus protection |
| hwdata_o | output | 32 | Bus write data |
| hrdata_i | input | 32 | Bus read data |
| hready_i | input | 1 | Bus transfer done |
| hresp_i | input | 1 | Bus error response |

## Verification
The hardest case to reach is an error partway through a packed sequence, which must stop the remaining beats and freeze the address on the element that failed. The bench's slave model matches the error against one chosen byte address. The stimulus starts a byte-packed read two elements below that address, so the failure falls on the third beat. The bench then counts beats and reads the address register back. Wrap-around inside a packed sequence is reached the same way, by placing the start address two bytes below the top of a 1KB window.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 8;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_DATA  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_BASE  = 8'hF8;
  localparam logic [OFS_W-1:0] OFS_IDENT = 8'hFC;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

  typedef enum logic [1:0] {
    INC_OFF    = 2'b00,
    INC_SINGLE = 2'b01,
    INC_PACKED = 2'b10,
    INC_RSVD   = 2'b11
  } inc_mode_e;

  typedef struct packed {
    logic       err;
    logic       sec_n;
    logic [4:0] prot;
    logic [3:0] mode;
    inc_mode_e  inc;
    logic [2:0] size;
  } ctrl_t;

  typedef enum logic [1:0] {H_IDLE, H_BUS, H_RESP} host_st_e;
  typedef enum logic [1:0] {B_IDLE, B_ADDR, B_DATA} bus_st_e;

  function automatic logic [2:0] size_step(input logic [2:0] sz);
    case (sz)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmap_csr.sv
module dmap_csr import dmap_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_addr_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              err_set_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] tar_o,
  output logic [DATA_W-1:0] drw_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o.err   <= 1'b0;
      ctrl_o.sec_n <= 1'b1;
      ctrl_o.prot  <= 5'b00011;
      ctrl_o.mode  <= 4'h0;
      ctrl_o.inc   <= INC_OFF;
      ctrl_o.size  <= SZ_WORD;
    end else begin
      if (wr_ctrl_i) begin
        ctrl_o.sec_n <= wdata_i[30];
        ctrl_o.prot  <= wdata_i[28:24];
        ctrl_o.mode  <= wdata_i[11:8];
        ctrl_o.inc   <= inc_mode_e'(wdata_i[5:4]);
        ctrl_o.size  <= wdata_i[2:0];
      end
      if (err_set_i)
        ctrl_o.err <= 1'b1;
      else if (wr_ctrl_i && wdata_i[31])
        ctrl_o.err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tar_o <= '0;
    end else if (wr_addr_i) begin
      tar_o <= wdata_i;
    end else if (adv_i) begin
      tar_o <= next_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drw_o <= '0;
    end else if (wr_data_i) begin
      drw_o <= wdata_i;
    end else if (cap_i) begin
      drw_o <= cap_data_i;
    end
  end
endmodule

// File: rtl/dmap_lane_path.sv
module dmap_lane_path import dmap_pkg::*; #(
  parameter int unsigned WRAP_BITS = 10
) (
  input  logic [ADDR_W-1:0] tar_i,
  input  logic [2:0]        size_i,
  input  logic              banked_i,
  input  logic [1:0]        bank_idx_i,
  input  logic              packed_i,
  input  logic [1:0]        beat_idx_i,
  input  logic [DATA_W-1:0] drw_i,
  input  logic [DATA_W-1:0] hrdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [DATA_W-1:0] hwdata_o,
  output logic [DATA_W-1:0] cap_data_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [WRAP_BITS-1:0] low_next;
  logic [7:0]           byte_k;
  logic [15:0]          half_k;

  assign bus_addr_o  = banked_i ? {tar_i[ADDR_W-1:4], bank_idx_i, 2'b00} : tar_i;
  assign low_next    = tar_i[WRAP_BITS-1:0] + WRAP_BITS'(size_step(size_i));
  assign next_addr_o = {tar_i[ADDR_W-1:WRAP_BITS], low_next};

  assign byte_k = drw_i[{beat_idx_i, 3'b000} +: 8];
  assign half_k = drw_i[{beat_idx_i[0], 4'b0000} +: 16];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hwdata_o[8*g +: 8] = !packed_i          ? drw_i[8*g +: 8] :
                                (size_i == SZ_BYTE) ? byte_k : half_k[8*(g%2) +: 8];
  end

  always_comb begin
    cap_data_o = drw_i;
    if (!packed_i)
      cap_data_o = hrdata_i;
    else if (size_i == SZ_BYTE)
      cap_data_o[{beat_idx_i, 3'b000} +: 8] = hrdata_i[{tar_i[1:0], 3'b000} +: 8];
    else
      cap_data_o[{beat_idx_i[0], 4'b0000} +: 16] = hrdata_i[{tar_i[1], 4'b0000} +: 16];
  end
endmodule

// File: rtl/dmap_bus_fsm.sv
module dmap_bus_fsm import dmap_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] nbeats_i,
  input  logic       hready_i,
  input  logic       hresp_i,
  output logic [1:0] htrans_o,
  output logic       busy_o,
  output logic       beat_ok_o,
  output logic [1:0] beat_idx_o,
  output logic       done_o,
  output logic       err_o
);
  bus_st_e    st;
  logic [2:0] cnt;
  logic [2:0] total;
  logic       beat_end;
  logic       last;

  assign beat_end   = (st == B_DATA) && hready_i;
  assign last       = (cnt + 3'd1) == total;
  assign beat_ok_o  = beat_end && !hresp_i;
  assign done_o     = beat_end && (hresp_i || last);
  assign err_o      = beat_end && hresp_i;
  assign beat_idx_o = cnt[1:0];
  assign busy_o     = (st != B_IDLE);
  assign htrans_o   = (st == B_ADDR) ? TR_NONSEQ : TR_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= B_IDLE;
      cnt   <= '0;
      total <= 3'd1;
    end else begin
      case (st)
        B_IDLE: if (start_i) begin
          st    <= B_ADDR;
          cnt   <= '0;
          total <= nbeats_i;
        end
        B_ADDR: if (hready_i) st <= B_DATA;
        B_DATA: if (hready_i) begin
          if (hresp_i || last) begin
            st <= B_IDLE;
          end else begin
            cnt <= cnt + 3'd1;
            st  <= B_ADDR;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmap_engine.sv
module dmap_engine import dmap_pkg::*; #(
  parameter int unsigned WRAP_BITS = 10,
  parameter logic [31:0] IDR_VALUE = 32'h1A05_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_offset_i,
  input  logic [31:0] req_wdata_i,
  output logic [31:0] rsp_rdata_o,
  input  logic        dbg_en_i,
  input  logic        sec_en_i,
  input  logic [31:0] rom_base_i,
  output logic [31:0] haddr_o,
  output logic [1:0]  htrans_o,
  output logic        hwrite_o,
  output logic [2:0]  hsize_o,
  output logic [6:0]  hprot_o,
  output logic [31:0] hwdata_o,
  input  logic [31:0] hrdata_i,
  input  logic        hready_i,
  input  logic        hresp_i
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] tar, next_addr;
  logic [DATA_W-1:0] drw, cap_data;
  host_st_e          hst;
  logic              wr_q, bank_q, packed_q;
  logic [1:0]        bidx_q;

  logic is_data, is_bank, needs_bus, blocked, accept_bus, pack_now;
  logic wr_ctrl, wr_addr, wr_data;
  logic [2:0] nbeats, size_eff;
  logic bus_busy, beat_ok, bus_done, bus_err;
  logic [1:0] beat_idx;
  logic bus_start, adv, cap, err_set;

  assign is_data   = (req_offset_i == OFS_DATA);
  assign is_bank   = (req_offset_i[7:4] == 4'h1) && (req_offset_i[1:0] == 2'b00);
  assign needs_bus = is_data || is_bank;

  assign blocked = !dbg_en_i
                || (!ctrl.sec_n && !sec_en_i)
                || (is_data && (ctrl.inc == INC_RSVD || ctrl.size > SZ_WORD));

  assign accept_bus = (hst == H_IDLE) && req_valid_i && needs_bus;
  assign bus_start  = accept_bus && !blocked;

  assign pack_now = is_data && (ctrl.inc == INC_PACKED) && (ctrl.size != SZ_WORD);
  assign nbeats   = !pack_now ? 3'd1 : (ctrl.size == SZ_BYTE ? 3'd4 : 3'd2);

  assign wr_ctrl = (hst == H_IDLE) && req_valid_i && req_write_i && (req_offset_i == OFS_CTRL);
  assign wr_addr = (hst == H_IDLE) && req_valid_i && req_write_i && (req_offset_i == OFS_ADDR);
  assign wr_data = accept_bus && req_write_i;

  assign adv     = beat_ok && !bank_q && (ctrl.inc == INC_SINGLE || ctrl.inc == INC_PACKED);
  assign cap     = beat_ok && !wr_q;
  assign err_set = (accept_bus && blocked) || bus_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst      <= H_IDLE;
      wr_q     <= 1'b0;
      bank_q   <= 1'b0;
      packed_q <= 1'b0;
      bidx_q   <= 2'b00;
    end else begin
      case (hst)
        H_IDLE: if (accept_bus) begin
          wr_q     <= req_write_i;
          bank_q   <= is_bank;
          packed_q <= pack_now;
          bidx_q   <= req_offset_i[3:2];
          hst      <= blocked ? H_RESP : H_BUS;
        end
        H_BUS:   if (bus_done) hst <= H_RESP;
        H_RESP:  hst <= H_IDLE;
        default: hst <= H_IDLE;
      endcase
    end
  end

  assign req_ready_o = ((hst == H_IDLE) && req_valid_i && !needs_bus) || (hst == H_RESP);

  always_comb begin
    rsp_rdata_o = '0;
    if (needs_bus) begin
      rsp_rdata_o = drw;
    end else begin
      case (req_offset_i)
        OFS_CTRL:  rsp_rdata_o = {ctrl.err, ctrl.sec_n, 1'b0, ctrl.prot, sec_en_i, 11'b0,
                                  ctrl.mode, bus_busy, dbg_en_i, ctrl.inc, 1'b0, ctrl.size};
        OFS_ADDR:  rsp_rdata_o = tar;
        OFS_BASE:  rsp_rdata_o = rom_base_i | 32'h0000_0002;
        OFS_IDENT: rsp_rdata_o = IDR_VALUE | 32'h0001_0000;
        default:   rsp_rdata_o = '0;
      endcase
    end
  end

  assign size_eff = bank_q ? SZ_WORD : ctrl.size;
  assign hsize_o  = size_eff;
  assign hwrite_o = wr_q;
  assign hprot_o  = {ctrl.sec_n | ~sec_en_i, 1'b0, ctrl.prot};

  dmap_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl_i(wr_ctrl), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wdata_i(req_wdata_i),
    .adv_i(adv), .next_addr_i(next_addr),
    .cap_i(cap), .cap_data_i(cap_data),
    .err_set_i(err_set),
    .ctrl_o(ctrl), .tar_o(tar), .drw_o(drw)
  );

  dmap_lane_path #(.WRAP_BITS(WRAP_BITS)) u_lane (
    .tar_i(tar), .size_i(size_eff), .banked_i(bank_q), .bank_idx_i(bidx_q),
    .packed_i(packed_q), .beat_idx_i(beat_idx), .drw_i(drw), .hrdata_i(hrdata_i),
    .bus_addr_o(haddr_o), .next_addr_o(next_addr),
    .hwdata_o(hwdata_o), .cap_data_o(cap_data)
  );

  dmap_bus_fsm u_bus (
    .clk(clk), .rst_n(rst_n),
    .start_i(bus_start), .nbeats_i(nbeats),
    .hready_i(hready_i), .hresp_i(hresp_i),
    .htrans_o(htrans_o), .busy_o(bus_busy),
    .beat_ok_o(beat_ok), .beat_idx_o(beat_idx),
    .done_o(bus_done), .err_o(bus_err)
  );
endmodule

// File: rtl/dmap_engine_chk.sv
module dmap_engine_chk #(
  parameter int unsigned WRAP_BITS = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  htrans,
  input logic [31:0] haddr,
  input logic        hready,
  input logic        dbg_en,
  input logic        sec_en,
  input logic        sec_n,
  input logic        bus_busy,
  input logic        bus_done,
  input logic        req_ready,
  input logic        err_flag,
  input logic        ctrl_wr,
  input logic        wdata31,
  input logic [31:0] tar
);
  p_trans_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b00) || (htrans == 2'b10));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)));

  p_single_outst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && hready) |=> (htrans == 2'b00));

  p_ready_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> req_ready);

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (tar[31:WRAP_BITS] == $past(tar[31:WRAP_BITS])));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(ctrl_wr && wdata31)) |=> err_flag);

  p_secure_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_n && !sec_en && !bus_busy) |=> (htrans == 2'b00));

  p_dbg_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_en && !bus_busy) |=> (htrans == 2'b00));
endmodule

bind dmap_engine dmap_engine_chk #(.WRAP_BITS(WRAP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .htrans(htrans_o), .haddr(haddr_o), .hready(hready_i),
  .dbg_en(dbg_en_i), .sec_en(sec_en_i), .sec_n(ctrl.sec_n), .bus_busy(bus_busy),
  .bus_done(bus_done), .req_ready(req_ready_o), .err_flag(ctrl.err),
  .ctrl_wr(wr_ctrl), .wdata31(req_wdata_i[31]), .tar(tar)
);

// File: tb/dmap_engine_bench.sv
module dmap_engine_bench;
  localparam logic [31:0] IDR_DEF = 32'h1A05_0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        dbg_en = 1'b1, sec_en = 1'b1;
  logic [31:0] rom_base = 32'h8000_1000;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic        hwrite, s_ready, s_resp;
  logic [2:0]  hsize;
  logic [6:0]  hprot;

  dmap_engine u_dmap_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_offset_i(req_offset), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .dbg_en_i(dbg_en), .sec_en_i(sec_en), .rom_base_i(rom_base),
    .haddr_o(haddr), .htrans_o(htrans), .hwrite_o(hwrite), .hsize_o(hsize),
    .hprot_o(hprot), .hwdata_o(hwdata), .hrdata_i(hrdata),
    .hready_i(s_ready), .hresp_i(s_resp)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  // slave model
  int          wait_cfg = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        dp;
  int          cnt;
  logic [31:0] dp_addr;
  logic        dp_w;
  logic [2:0]  dp_sz;
  logic [6:0]  dp_prot;
  int          nlog;
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic [2:0]  log_sz   [8];
  logic [6:0]  log_prot [8];
  logic        log_w    [8];

  assign s_ready = !dp || (cnt >= wait_cfg);
  assign hrdata  = pat(dp_addr);
  assign s_resp  = dp && s_ready && err_en && (dp_addr == err_addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      dp <= 1'b0; cnt <= 0; nlog <= 0; dp_addr <= '0;
      dp_w <= 1'b0; dp_sz <= '0; dp_prot <= '0;
    end else begin
      if (dp && s_ready) begin
        log_addr[nlog % 8] <= dp_addr;
        log_data[nlog % 8] <= dp_w ? hwdata : hrdata;
        log_sz[nlog % 8]   <= dp_sz;
        log_prot[nlog % 8] <= dp_prot;
        log_w[nlog % 8]    <= dp_w;
        nlog <= nlog + 1;
      end
      if (htrans == 2'b10 && s_ready) begin
        dp <= 1'b1; cnt <= 0; dp_addr <= haddr; dp_w <= hwrite;
        dp_sz <= hsize; dp_prot <= hprot;
      end else if (dp && s_ready) begin
        dp <= 1'b0;
      end else if (dp) begin
        cnt <= cnt + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] rd_v;
  int          st_v;

  task automatic acc(input logic w, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = off; req_wdata = d;
    st_v = 0;
    #1;
    while (!req_ready) begin
      st_v++;
      @(negedge clk);
      #1;
    end
    rd_v = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    acc(1'b1, off, d);
  endtask

  task automatic rd(input logic [7:0] off);
    acc(1'b0, off, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog actual=hang expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int base;
    logic [31:0] s, e, ctrl_v;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00); chk("R1 ctrl reset", rd_v, 32'h4380_0042);
    rd(8'h04); chk("R1 addr reset", rd_v, 32'h0);

    // R3 identity and base
    rd(8'hFC); chk("R3 identity", rd_v, IDR_DEF | 32'h0001_0000);
    rd(8'hF8); chk("R3 base", rd_v, 32'h8000_1002);

    // R2 field positions and unmapped offsets
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p;
      p = 32'h3A5C_96E1 * (k + 1) ^ (32'h4000_0000 * k[0]);
      p[31] = 1'b0;
      p[5:4] = 2'b00;
      wr(8'h00, p);
      rd(8'h00);
      chk("R2 ctrl fields", rd_v, (p & 32'h5F00_0F37) | 32'h0080_0040);
    end
    wr(8'h00, 32'h4300_0002);
    wr(8'h04, 32'h0000_1234);
    base = nlog;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08); chk("R2 unmapped read", rd_v, 32'h0);
    rd(8'h11); chk("R2 misaligned read", rd_v, 32'h0);
    rd(8'h04); chk("R2 unmapped write ignored", rd_v, 32'h0000_1234);
    chk("R2 no bus beats", nlog - base, 0);

    // R4 R5 R6 sweep: size x increment mode x start address x wait states
    for (int sz = 0; sz < 3; sz++) begin
      for (int inc = 0; inc < 2; inc++) begin
        for (int k = 0; k < 6; k++) begin
          int step;
          step = 1 << sz;
          s = 32'h0012_3000 + (k << 14);
          s[9:0] = (k == 0) ? 10'h3FF : 10'(k * 173);
          s = s & ~(step - 1);
          wait_cfg = k % 3;
          wr(8'h00, 32'h4300_0000 | (inc << 4) | sz);
          wr(8'h04, s);
          base = nlog;
          rd(8'h0C);
          chk("R5 stall cycles", st_v, wait_cfg + 3);
          chk("R4 read data", rd_v, pat(s));
          chk("R4 one beat", nlog - base, 1);
          chk("R4 beat addr", log_addr[base % 8], s);
          chk("R4 beat size", log_sz[base % 8], sz);
          e = s;
          if (inc == 1) e[9:0] = s[9:0] + 10'(step);
          rd(8'h04);
          chk("R6 address advance", rd_v, e);
        end
      end
    end
    wait_cfg = 1;

    // R4 write data
    wr(8'h00, 32'h4300_0002);
    wr(8'h04, 32'h0000_2220);
    base = nlog;
    wr(8'h0C, 32'hDEAD_BEEF);
    chk("R4 write data", log_data[base % 8], 32'hDEAD_BEEF);
    chk("R4 write flag", log_w[base % 8], 1);

    // R6 wrap across the 1KB window
    wr(8'h00, 32'h4300_0012);
    wr(8'h04, 32'h0000_17F8);
    base = nlog;
    for (int i = 0; i < 4; i++) wr(8'h0C, 32'h100 + i);
    chk("R6 wrap addr0", log_addr[base % 8], 32'h17F8);
    chk("R6 wrap addr1", log_addr[(base + 1) % 8], 32'h17FC);
    chk("R6 wrap addr2", log_addr[(base + 2) % 8], 32'h1400);
    chk("R6 wrap addr3", log_addr[(base + 3) % 8], 32'h1404);
    rd(8'h04); chk("R6 wrap final", rd_v, 32'h0000_1408);

    // R7 error response, sticky flag, write-one clear
    wr(8'h04, 32'h0000_2000);
    err_en = 1'b1; err_addr = 32'h0000_2000;
    rd(8'h0C);
    rd(8'h04); chk("R7 no advance on error", rd_v, 32'h0000_2000);
    rd(8'h00); chk("R7 error set", rd_v[31], 1);
    err_en = 1'b0;
    rd(8'h0C);
    rd(8'h04); chk("R7 advance after clean", rd_v, 32'h0000_2004);
    rd(8'h00); chk("R7 error sticky", rd_v[31], 1);
    wr(8'h00, 32'hC300_0012);
    rd(8'h00); chk("R7 error cleared", rd_v[31], 0);

    // R8 banked
    wr(8'h00, 32'h4300_0010);
    wr(8'h04, 32'h5555_1234);
    for (int n = 0; n < 4; n++) begin
      base = nlog;
      wr(8'h10 + 8'(n * 4), 32'h1000 + n);
      chk("R8 bank addr", log_addr[base % 8], 32'h5555_1230 + 4 * n);
      chk("R8 bank size", log_sz[base % 8], 3'b010);
      chk("R8 bank data", log_data[base % 8], 32'h1000 + n);
    end
    rd(8'h18); chk("R8 bank read", rd_v, pat(32'h5555_1238));
    rd(8'h04); chk("R8 addr kept", rd_v, 32'h5555_1234);
    wr(8'h00, 32'h4300_0033);
    base = nlog;
    rd(8'h1C); chk("R8 size and mode ignored", nlog - base, 1);

    // R9 packed byte read wrapping
    wr(8'h00, 32'h4300_0020);
    wr(8'h04, 32'h0000_73FE);
    base = nlog;
    rd(8'h0C);
    chk("R9 byte beats", nlog - base, 4);
    begin
      logic [31:0] ex;
      logic [31:0] ak [4];
      ak[0] = 32'h73FE; ak[1] = 32'h73FF; ak[2] = 32'h7000; ak[3] = 32'h7001;
      for (int b = 0; b < 4; b++) begin
        logic [31:0] pw;
        pw = pat(ak[b]);
        ex[8*b +: 8] = pw[8*ak[b][1:0] +: 8];
        chk("R9 byte beat addr", log_addr[(base + b) % 8], ak[b]);
      end
      chk("R9 byte read data", rd_v, ex);
    end
    rd(8'h04); chk("R9 byte final addr", rd_v, 32'h0000_7002);

    // R9 packed half write
    wr(8'h00, 32'h4300_0021);
    wr(8'h04, 32'h0000_93FC);
    base = nlog;
    wr(8'h0C, 32'hBEEF_CAFE);
    chk("R9 half beats", nlog - base, 2);
    chk("R9 half data0", log_data[base % 8], 32'hCAFE_CAFE);
    chk("R9 half data1", log_data[(base + 1) % 8], 32'hBEEF_BEEF);
    chk("R9 half addr1", log_addr[(base + 1) % 8], 32'h93FE);
    rd(8'h04); chk("R9 half final addr", rd_v, 32'h0000_9000);

    // R9 packed word behaves as single
    wr(8'h00, 32'h4300_0022);
    wr(8'h04, 32'h0000_0040);
    base = nlog;
    rd(8'h0C);
    chk("R9 word one beat", nlog - base, 1);
    rd(8'h04); chk("R9 word advance", rd_v, 32'h0000_0044);

    // R13 packed error mid-sequence
    wr(8'h00, 32'h4300_0020);
    wr(8'h04, 32'h0000_0100);
    err_en = 1'b1; err_addr = 32'h0000_0102;
    base = nlog;
    rd(8'h0C);
    err_en = 1'b0;
    chk("R13 beats stop", nlog - base, 3);
    rd(8'h04); chk("R13 addr at failure", rd_v, 32'h0000_0102);
    rd(8'h00); chk("R13 error set", rd_v[31], 1);
    wr(8'h00, 32'hC300_0002);

    // R10 reserved increment and size
    wr(8'h00, 32'h4300_0032);
    base = nlog;
    rd(8'h0C);
    chk("R10 rsvd inc no beat", nlog - base, 0);
    rd(8'h00); chk("R10 rsvd inc error", rd_v[31], 1);
    wr(8'h00, 32'hC300_0013);
    base = nlog;
    rd(8'h0C);
    chk("R10 rsvd size no beat", nlog - base, 0);
    rd(8'h00); chk("R10 rsvd size error", rd_v[31], 1);

    // R11 security gating and protection
    wr(8'h00, 32'h9500_0002);
    base = nlog;
    rd(8'h0C);
    chk("R11 secure allowed", nlog - base, 1);
    chk("R11 prot secure", log_prot[base % 8], 7'h15);
    sec_en = 1'b0;
    #1; chk("R11 prot bit6 high", hprot, 7'h55);
    base = nlog;
    rd(8'h0C);
    chk("R11 secure blocked", nlog - base, 0);
    rd(8'h00); chk("R11 blocked error", rd_v, 32'h9500_0042);
    wr(8'h00, 32'hD500_0002);
    base = nlog;
    rd(8'h0C);
    chk("R11 nonsecure ignores enable", nlog - base, 1);
    chk("R11 prot nonsecure", log_prot[base % 8], 7'h55);
    sec_en = 1'b1;

    // R12 debug enable
    dbg_en = 1'b0;
    rd(8'h00); chk("R12 status bits", rd_v, 32'h5580_0002);
    base = nlog;
    wr(8'h0C, 32'h1);
    chk("R12 debug blocked", nlog - base, 0);
    rd(8'h00); chk("R12 blocked error", rd_v[31], 1);
    dbg_en = 1'b1;
    ctrl_v = 32'hC300_0002;
    wr(8'h00, ctrl_v);
    rd(8'h00); chk("R12 status restored", rd_v, 32'h4380_0042);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule